// File: doc/BRIEF.md
# Masked Packed Unsigned-to-Float Converter

This block converts a vector of packed unsigned 32-bit integers into IEEE-754 single-precision values, one lane at a time, all lanes in parallel. A vector-length select sets how many 32-bit lanes take part: 4, 8 or 16. A per-lane write mask picks which of those lanes take a converted result. Lanes that are masked off either keep the prior destination lane or are written with zero, depending on the masking mode. Every destination bit above the active length is cleared.

The rounding direction normally comes from a global rounding field. An instruction-level override field takes its place only when the length is 512 bits and the broadcast/override bit is set on a register source. When the source is in memory and the same bit is set, one 32-bit scalar is broadcast to every lane instead. A reserved 4-bit operand field must read all ones. Any other value raises an undefined-instruction fault and leaves the destination untouched. The only numeric flag is inexact, ORed over the lanes that were actually written. Results appear in registers one clock after the input strobe.

Top module: `u2f_converter`

## Requirements
- R1: `vlSel` 2'b00 gives 4 active lanes (bits 127:0), 2'b01 gives 8 lanes (255:0), and 2'b10 or 2'b11 gives 16 lanes (511:0). Lane j occupies bits 32j+31:32j.
- R2: Each written lane holds the single-precision encoding of its unsigned source: sign 0, exponent biased by 127, 23-bit fraction. A zero source gives 32'h0000_0000 and is exact.
- R3: The rounding code is 2'b00 nearest-even, 2'b01 toward minus infinity, 2'b10 toward plus infinity, 2'b11 toward zero. A carry out of rounding raises the exponent (for example, 32'hFFFF_FFFF gives 32'h4F80_0000 with nearest-even and 32'h4F7F_FFFF with toward-zero).
- R4: With `maskEn` low, every active lane is written with its converted value. With `maskEn` high, only the active lanes whose `laneMask` bit is 1 are written.
- R5: An active lane that is masked off takes the matching lane of `priorDst` when `zeroMode` is 0, and 32'h0 when `zeroMode` is 1.
- R6: The rounding code comes from `embRc` only when the length is 512 bits, `bcastRc` is 1 and `memSrc` is 0. In every other case it comes from `globalRc`.
- R7: When `memSrc` and `bcastRc` are both 1, every lane converts `bcastScalar` instead of its own `srcVec` lane.
- R8: Destination bits from the active length up to bit 511 are 0 after a committed operation.
- R9: When `inValid` is 1 and `rsvdField` is not 4'b1111, `udFault` is 1 in the next cycle, `inexact` is 0 and `dstVec` keeps its previous value. When `rsvdField` is 4'b1111, `udFault` is 0.
- R10: `inexact` is the OR, over written lanes only, of "the conversion discarded nonzero bits". Masked-off lanes never set it.
- R11: `outValid`, `dstVec`, `inexact` and `udFault` update one clock after `inValid` is sampled high. `outValid` is 0 in the cycle after `inValid` is low, and the other outputs then hold.
- R12: After reset, `dstVec` is 0 and `outValid`, `inexact` and `udFault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| srcVec | input | 512 | Packed unsigned source lanes |
| bcastScalar | input | 32 | Scalar used for broadcast from memory |
| priorDst | input | 512 | Previous destination contents for merge masking |
| laneMask | input | 16 | Per-lane write mask |
| maskEn | input | 1 | 1 = write mask applies |
| vlSel | input | 2 | Vector length select |
| zeroMode | input | 1 | 1 = zero masked-off lanes, 0 = merge |
| bcastRc | input | 1 | Broadcast (memory source) or rounding override (register source) |
| memSrc | input | 1 | 1 = source operand comes from memory |
| embRc | input | 2 | Rounding code carried by the instruction |
| globalRc | input | 2 | Global rounding code |
| rsvdField | input | 4 | Reserved operand field, must be 4'b1111 |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| dstVec | output | 512 | Destination vector |
| inexact | output | 1 | Precision flag over written lanes |
| udFault | output | 1 | Undefined-instruction fault |

## Verification
The assertions take the control inputs to be well-defined (no X) in every cycle where `inValid` is high. They also assume that reset is applied before the first strobe, so that "holds its previous value" refers to a value the block itself has produced. The stimulus drives every field on the falling edge and holds it for a whole cycle. It inserts idle cycles between operations so that the hold properties are exercised. Beyond directed cases, it draws random fields and uses the reserved value 4'b1111 in most operations, so that faulting and committing operations are interleaved.

// File: rtl/u2f_pkg.sv
package u2f_pkg;
  parameter int LANE_W    = 32;
  parameter int MAX_LANES = 16;
  parameter int VEC_W     = LANE_W * MAX_LANES;
  parameter int FRAC_W    = 23;
  parameter int EXP_BIAS  = 127;
  parameter logic [3:0] RSVD_OK = 4'b1111;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } roundMode_e;

  typedef struct packed {
    logic                 commit;
    logic                 fault;
    logic                 useBcast;
    roundMode_e           rmode;
    logic [MAX_LANES-1:0] laneWrite;
    logic [MAX_LANES-1:0] laneZero;
  } ctrlStrobe_t;
endpackage

// File: rtl/u2f_lane.sv
module u2f_lane
  import u2f_pkg::*;
(
  input  logic [LANE_W-1:0] intIn,
  input  roundMode_e        rmode,
  output logic [LANE_W-1:0] fpOut,
  output logic              laneInexact
);
  localparam int LZ_W   = $clog2(LANE_W);
  localparam int EXP_W  = 8;
  localparam int DROP_W = LANE_W - 1 - FRAC_W;
  localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(EXP_BIAS + LANE_W - 1);

  logic [LZ_W-1:0]   leadZeros;
  logic              anyOne;
  logic [LANE_W-1:0] normVal;
  logic [FRAC_W-1:0] fracRaw;
  logic              guardBit;
  logic              stickyBit;
  logic              roundUp;
  logic [FRAC_W+1:0] sigRounded;
  logic [EXP_W-1:0]  expBase;
  logic [EXP_W-1:0]  expFinal;
  logic [FRAC_W-1:0] fracFinal;

  always_comb begin
    leadZeros = '0;
    anyOne    = 1'b0;
    for (int i = LANE_W - 1; i >= 0; i--) begin
      if (!anyOne && intIn[i]) begin
        leadZeros = LZ_W'(LANE_W - 1 - i);
        anyOne    = 1'b1;
      end
    end
  end

  assign normVal   = intIn << leadZeros;
  assign fracRaw   = normVal[LANE_W-2 -: FRAC_W];
  assign guardBit  = normVal[DROP_W-1];
  assign stickyBit = |normVal[DROP_W-2:0];

  always_comb begin
    unique case (rmode)
      RM_NEAR: roundUp = guardBit & (stickyBit | fracRaw[0]);
      RM_UP:   roundUp = guardBit | stickyBit;
      RM_DOWN: roundUp = 1'b0;
      RM_ZERO: roundUp = 1'b0;
      default: roundUp = 1'b0;
    endcase
  end

  assign sigRounded = {2'b01, fracRaw} + {{(FRAC_W+1){1'b0}}, roundUp};
  assign expBase    = EXP_TOP - EXP_W'(leadZeros);

  always_comb begin
    if (sigRounded[FRAC_W+1]) begin
      expFinal  = expBase + 1'b1;
      fracFinal = '0;
    end else begin
      expFinal  = expBase;
      fracFinal = sigRounded[FRAC_W-1:0];
    end
  end

  always_comb begin
    if (!anyOne) begin
      fpOut       = '0;
      laneInexact = 1'b0;
    end else begin
      fpOut       = {1'b0, expFinal, fracFinal};
      laneInexact = guardBit | stickyBit;
    end
  end
endmodule

// File: rtl/u2f_ctrl.sv
module u2f_ctrl
  import u2f_pkg::*;
(
  input  logic                 inValid,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic                 maskEn,
  input  logic [1:0]           vlSel,
  input  logic                 zeroMode,
  input  logic                 bcastRc,
  input  logic                 memSrc,
  input  logic [1:0]           embRc,
  input  logic [1:0]           globalRc,
  input  logic [3:0]           rsvdField,
  output ctrlStrobe_t          strb
);
  localparam int CNT_W    = $clog2(MAX_LANES) + 1;
  localparam int LANES_S  = MAX_LANES / 4;
  localparam int LANES_M  = MAX_LANES / 2;

  logic [CNT_W-1:0]     laneCount;
  logic                 fullLength;
  logic                 useOverride;
  logic [MAX_LANES-1:0] laneActive;
  logic                 rsvdGood;

  always_comb begin
    unique case (vlSel)
      2'b00:   laneCount = CNT_W'(LANES_S);
      2'b01:   laneCount = CNT_W'(LANES_M);
      default: laneCount = CNT_W'(MAX_LANES);
    endcase
  end

  assign fullLength  = (laneCount == CNT_W'(MAX_LANES));
  assign useOverride = fullLength && bcastRc && !memSrc;
  assign rsvdGood    = (rsvdField == RSVD_OK);

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane_ctl
    assign laneActive[j]     = (CNT_W'(j) < laneCount);
    assign strb.laneWrite[j] = laneActive[j] && (!maskEn || laneMask[j]);
    assign strb.laneZero[j]  = !strb.laneWrite[j] && (!laneActive[j] || zeroMode);
  end

  assign strb.commit   = inValid && rsvdGood;
  assign strb.fault    = inValid && !rsvdGood;
  assign strb.useBcast = memSrc && bcastRc;
  assign strb.rmode    = roundMode_e'(useOverride ? embRc : globalRc);
endmodule

// File: rtl/u2f_datapath.sv
module u2f_datapath
  import u2f_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [VEC_W-1:0]  srcVec,
  input  logic [LANE_W-1:0] bcastScalar,
  input  logic [VEC_W-1:0]  priorDst,
  output logic              outValid,
  output logic [VEC_W-1:0]  dstVec,
  output logic              inexact,
  output logic              udFault
);
  logic [VEC_W-1:0]     nextDst;
  logic [MAX_LANES-1:0] laneInexact;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [LANE_W-1:0] laneSrc;
    logic [LANE_W-1:0] laneFp;

    assign laneSrc = strb.useBcast ? bcastScalar : srcVec[j*LANE_W +: LANE_W];

    u2f_lane i_lane (
      .intIn      (laneSrc),
      .rmode      (strb.rmode),
      .fpOut      (laneFp),
      .laneInexact(laneInexact[j])
    );

    always_comb begin
      if (strb.laneWrite[j])
        nextDst[j*LANE_W +: LANE_W] = laneFp;
      else if (strb.laneZero[j])
        nextDst[j*LANE_W +: LANE_W] = '0;
      else
        nextDst[j*LANE_W +: LANE_W] = priorDst[j*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      dstVec   <= '0;
      inexact  <= 1'b0;
      udFault  <= 1'b0;
    end else begin
      outValid <= strb.commit | strb.fault;
      if (strb.commit) begin
        dstVec  <= nextDst;
        inexact <= |(laneInexact & strb.laneWrite);
        udFault <= 1'b0;
      end else if (strb.fault) begin
        inexact <= 1'b0;
        udFault <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/u2f_converter.sv
module u2f_converter
  import u2f_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [VEC_W-1:0]     srcVec,
  input  logic [LANE_W-1:0]    bcastScalar,
  input  logic [VEC_W-1:0]     priorDst,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic                 maskEn,
  input  logic [1:0]           vlSel,
  input  logic                 zeroMode,
  input  logic                 bcastRc,
  input  logic                 memSrc,
  input  logic [1:0]           embRc,
  input  logic [1:0]           globalRc,
  input  logic [3:0]           rsvdField,
  output logic                 outValid,
  output logic [VEC_W-1:0]     dstVec,
  output logic                 inexact,
  output logic                 udFault
);
  ctrlStrobe_t strb;

  u2f_ctrl i_ctrl (
    .inValid  (inValid),
    .laneMask (laneMask),
    .maskEn   (maskEn),
    .vlSel    (vlSel),
    .zeroMode (zeroMode),
    .bcastRc  (bcastRc),
    .memSrc   (memSrc),
    .embRc    (embRc),
    .globalRc (globalRc),
    .rsvdField(rsvdField),
    .strb     (strb)
  );

  u2f_datapath i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .srcVec     (srcVec),
    .bcastScalar(bcastScalar),
    .priorDst   (priorDst),
    .outValid   (outValid),
    .dstVec     (dstVec),
    .inexact    (inexact),
    .udFault    (udFault)
  );
endmodule

// File: rtl/u2f_checker.sv
module u2f_checker
  import u2f_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [MAX_LANES-1:0] laneMask,
  input logic                 maskEn,
  input logic [1:0]           vlSel,
  input logic                 zeroMode,
  input logic [3:0]           rsvdField,
  input logic                 outValid,
  input logic [VEC_W-1:0]     dstVec,
  input logic                 inexact,
  input logic                 udFault
);
  localparam int SMALL_TOP = 4 * LANE_W;

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r11_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(dstVec) && $stable(inexact) && $stable(udFault));

  a_r9_fault_raised: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rsvdField != RSVD_OK) |=> (udFault && !inexact && $stable(dstVec)));

  a_r9_no_fault: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rsvdField == RSVD_OK) |=> !udFault);

  a_r8_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rsvdField == RSVD_OK && vlSel == 2'b00) |=> (dstVec[VEC_W-1:SMALL_TOP] == '0));

  a_r5_zero_lane0: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rsvdField == RSVD_OK && maskEn && zeroMode && !laneMask[0])
      |=> (dstVec[LANE_W-1:0] == '0));

  a_r10_fault_not_inexact: assert property (@(posedge clk) disable iff (!rstN)
    udFault |-> !inexact);
endmodule

bind u2f_converter u2f_checker i_chk (.*);

// File: tb/test_u2f_converter.sv
module test_u2f_converter;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;
  localparam int VW = 512;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [VW-1:0] srcVec = '0;
  logic [31:0]   bcastScalar = '0;
  logic [VW-1:0] priorDst = '0;
  logic [NL-1:0] laneMask = '0;
  logic          maskEn = 1'b0;
  logic [1:0]    vlSel = 2'b10;
  logic          zeroMode = 1'b0;
  logic          bcastRc = 1'b0;
  logic          memSrc = 1'b0;
  logic [1:0]    embRc = 2'b00;
  logic [1:0]    globalRc = 2'b00;
  logic [3:0]    rsvdField = 4'hF;
  logic          outValid;
  logic [VW-1:0] dstVec;
  logic          inexact;
  logic          udFault;

  int    testsRun = 0;
  int    testsFailed = 0;
  string curTag = "R12";
  string expTag = "R12";
  bit    checking = 1'b0;

  logic [VW-1:0] expDst = '0;
  logic          expValid = 1'b0;
  logic          expInexact = 1'b0;
  logic          expFault = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  u2f_converter i_u2f_converter (.*);

  function automatic logic [31:0] refConv(input logic [31:0] x, input logic [1:0] rm,
                                          output logic inx);
    int     msb;
    longint q, rem, half, sh;
    logic   up;
    inx = 1'b0;
    if (x == 0) return 32'h0;
    msb = 0;
    for (int i = 0; i < 32; i++) if (x[i]) msb = i;
    if (msb <= 23) begin
      q = longint'(x) << (23 - msb);
    end else begin
      sh   = msb - 23;
      q    = longint'(x) >> sh;
      rem  = longint'(x) - (q << sh);
      half = longint'(1) << (sh - 1);
      inx  = (rem != 0);
      case (rm)
        2'b00:   up = (rem > half) || (rem == half && q[0]);
        2'b10:   up = (rem != 0);
        default: up = 1'b0;
      endcase
      if (up) q = q + 1;
      if (q == (longint'(1) << 24)) begin
        q   = longint'(1) << 23;
        msb = msb + 1;
      end
    end
    return {1'b0, 8'(127 + msb), q[22:0]};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      expDst = '0; expValid = 1'b0; expInexact = 1'b0; expFault = 1'b0;
    end else begin
      expValid = inValid;
      expTag   = curTag;
      if (inValid && rsvdField != 4'hF) begin
        expFault = 1'b1; expInexact = 1'b0;
      end else if (inValid) begin
        int         lanes;
        logic [1:0] rm;
        logic       acc, li;
        logic [31:0] s;
        lanes = (vlSel == 2'b00) ? 4 : (vlSel == 2'b01) ? 8 : 16;
        rm    = (lanes == 16 && bcastRc && !memSrc) ? embRc : globalRc;
        acc   = 1'b0;
        for (int j = 0; j < NL; j++) begin
          if (j >= lanes) expDst[j*32 +: 32] = '0;
          else if (!maskEn || laneMask[j]) begin
            s = (memSrc && bcastRc) ? bcastScalar : srcVec[j*32 +: 32];
            expDst[j*32 +: 32] = refConv(s, rm, li);
            acc = acc | li;
          end else if (zeroMode) expDst[j*32 +: 32] = '0;
          else expDst[j*32 +: 32] = priorDst[j*32 +: 32];
        end
        expFault = 1'b0; expInexact = acc;
      end
    end
  end

  task automatic check1(input string what, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", expTag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check1("outValid", VW'(outValid), VW'(expValid));
      check1("dstVec", dstVec, expDst);
      check1("inexact", VW'(inexact), VW'(expInexact));
      check1("udFault", VW'(udFault), VW'(expFault));
    end
  end

  task automatic op(input string tag, input logic [1:0] vl, input logic mEn,
                    input logic [15:0] msk, input logic zm, input logic b, input logic mem,
                    input logic [1:0] er, input logic [1:0] gr, input logic [3:0] rs);
    @(negedge clk);
    curTag = tag; vlSel = vl; maskEn = mEn; laneMask = msk; zeroMode = zm;
    bcastRc = b; memSrc = mem; embRc = er; globalRc = gr; rsvdField = rs; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic fillSrc(input logic [31:0] a, input logic [31:0] b);
    for (int j = 0; j < NL; j++) srcVec[j*32 +: 32] = (j % 2 == 0) ? a + 32'(j * 977) : b - 32'(j * 131);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    testsRun++; testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int j = 0; j < NL; j++) priorDst[j*32 +: 32] = 32'hA5A5_0000 + 32'(j);
    repeat (3) @(negedge clk);
    checking = 1'b1;          // R12 reset state
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 R3 special values, 512 bits, no mask
    srcVec = '0;
    srcVec[31:0] = 32'h0; srcVec[63:32] = 32'h1; srcVec[95:64] = 32'hFFFF_FFFF;
    srcVec[127:96] = 32'd16777217; srcVec[159:128] = 32'd16777219;
    srcVec[191:160] = 32'h8000_0000; srcVec[223:192] = 32'h00FF_FFFF;
    for (int r = 0; r < 4; r++) op("R3", 2'b10, 1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00, 2'(r), 4'hF);
    op("R2", 2'b10, 1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF);
    // R1 R8 lengths
    fillSrc(32'h1234_5679, 32'hF000_0011);
    op("R1", 2'b00, 1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF);
    op("R8", 2'b01, 1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b01, 4'hF);
    op("R1", 2'b11, 1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10, 4'hF);
    // R6 override used only at full length, register source
    op("R6", 2'b10, 1'b0, '0, 1'b0, 1'b1, 1'b0, 2'b11, 2'b00, 4'hF);
    op("R6", 2'b01, 1'b0, '0, 1'b0, 1'b1, 1'b0, 2'b11, 2'b00, 4'hF);
    // R7 broadcast from memory
    bcastScalar = 32'hFFFF_FFFF;
    op("R7", 2'b01, 1'b0, '0, 1'b0, 1'b1, 1'b1, 2'b11, 2'b00, 4'hF);
    // R4 R5 masking
    op("R4", 2'b10, 1'b1, 16'hA5C3, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF);
    op("R5", 2'b10, 1'b1, 16'h3C5A, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF);
    // R10 inexact lanes masked off, written lanes exact
    srcVec = '0;
    for (int j = 0; j < NL; j++) srcVec[j*32 +: 32] = (j < 8) ? 32'(j + 5) : 32'hFFFF_FFF1;
    op("R10", 2'b10, 1'b1, 16'h00FF, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF);
    op("R10", 2'b10, 1'b1, 16'h0100, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF);
    // R9 reserved field fault
    op("R9", 2'b10, 1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hE);
    op("R9", 2'b00, 1'b0, '0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 4'h0);
    // R11 idle cycles hold outputs
    repeat (3) @(negedge clk);
    // random mix
    for (int n = 0; n < 300; n++) begin
      for (int j = 0; j < NL; j++) begin
        srcVec[j*32 +: 32] = $urandom >> ($urandom % 32);
        priorDst[j*32 +: 32] = $urandom;
      end
      bcastScalar = $urandom;
      op("R11", 2'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
         1'($urandom), 2'($urandom), 2'($urandom), ($urandom % 8 == 0) ? 4'($urandom) : 4'hF);
      if (n % 3 == 0) @(negedge clk);
    end
    @(negedge clk);
    checking = 1'b0;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule